// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This controller collects level-sensitive interrupt request lines, applies an enable mask written by software, and presents one request wire and an 8-bit vector to the processor core. It does not rank pending sources against each other. When exactly one enabled source is pending, the vector identifies that source. When several are pending, the vector is a single shared code, and software then reads the pending words to choose which source to serve.

The two highest input lines are handled separately. They never pass through the mask. They feed a non-maskable pending word, and a dedicated non-maskable output is raised while any bit of that word is set.

Software reaches the controller through a small 32-bit register port that uses word indices. Only the enable mask can be written. The other words are status and can only be read.

Top module: `masked_vec_irq`

## Requirements
- R1: After synchronous active-high reset, `irq_req`, `irq_vec` and `nmi_out` are 0, and every readable word returns 0.
- R2: Word index 0 holds the enable mask. A write there stores `wdata`. Read data for any index appears on `rdata` on the clock edge that samples `rd_en`.
- R3: Writes to word indices 1 to 7 leave the mask, the outputs and every readable word unchanged.
- R4: Input line n, for n from 1 to 29, sets pending bit n-1 of word index 1 while the line is high and clears it while the line is low. Line 0 has no effect. Bits 29 to 31 of word index 1 always read 0.
- R5: Word index 2 reads as the pending word of index 1 ANDed with the mask.
- R6: If no enabled source is pending, `irq_vec` is 0x00 and `irq_req` is 0.
- R7: If exactly one enabled pending bit i is set, `irq_vec` is 0x31 + i and `irq_req` is 1.
- R8: If two or more enabled pending bits are set, `irq_vec` is 0x30 and `irq_req` is 1.
- R9: Lines 30 and 31 set bits 30 and 31 of word index 3 at their level and never affect word index 1 or the vector. `nmi_out` is the OR of word index 3.
- R10: Word index 4 and the unused indices 5 to 7 read as 0.
- R11: `irq_vec`, `irq_req` and `nmi_out` change on the first clock edge after a change on an input line or a mask write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 32 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Interrupt vector |
| nmi_out | output | 1 | Non-maskable request |

## Verification
The bench builds the controller with its default parameters: shared vector 0x30, first single-source vector 0x31, and a 31-bit scan. With these values every maskable line from 1 to 29 can be swept one at a time, and each sweep step must give a distinct vector from 0x31 to 0x4D. Combining sources with different masks tests the collapse to the shared vector and the return to a single-source vector. Keeping the non-maskable lines high while the mask is fully open shows that those lines never reach the vector path.

// File: rtl/masked_vec_irq.sv
module masked_vec_irq #(
  parameter logic [7:0] SHARED_VEC = 8'h30,
  parameter logic [7:0] FIRST_VEC  = 8'h31,
  parameter int         SCAN_BITS  = 31
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] irq_lines,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vec,
  output logic        nmi_out
);
  localparam int W       = 32;
  localparam int NMI_LO  = 30;
  localparam int MASKABLE = NMI_LO - 1;

  logic [W-1:0] mask_q, raw_q, nmi_q;
  logic [W-1:0] mask_d, raw_d, nmi_d, enabled_d, enabled_q;

  assign raw_d     = {{(W-MASKABLE){1'b0}}, irq_lines[NMI_LO-1:1]};
  assign nmi_d     = {irq_lines[W-1:NMI_LO], {NMI_LO{1'b0}}};
  assign mask_d    = (wr_en && addr == 3'd0) ? wdata : mask_q;
  assign enabled_d = raw_d & mask_d;
  assign enabled_q = raw_q & mask_q;

  function automatic logic [7:0] pick_vec(input logic [W-1:0] m);
    int   cnt;
    logic [7:0] idx;
    cnt = 0;
    idx = 8'd0;
    for (int i = 0; i < SCAN_BITS; i++) begin
      if (m[i]) begin
        if (cnt == 0) idx = 8'(i);
        cnt++;
      end
    end
    if (cnt == 0)      pick_vec = 8'h00;
    else if (cnt == 1) pick_vec = FIRST_VEC + idx;
    else               pick_vec = SHARED_VEC;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      raw_q   <= '0;
      nmi_q   <= '0;
      irq_vec <= '0;
      irq_req <= 1'b0;
      nmi_out <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      raw_q   <= raw_d;
      nmi_q   <= nmi_d;
      irq_vec <= pick_vec(enabled_d);
      irq_req <= |enabled_d[SCAN_BITS-1:0];
      nmi_out <= |nmi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        3'd0:    rdata <= mask_q;
        3'd1:    rdata <= raw_q;
        3'd2:    rdata <= enabled_q;
        3'd3:    rdata <= nmi_q;
        default: rdata <= '0;
      endcase
    end
  end

  AST_REQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_vec != 8'h00)); // R7
  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (rst)
    (enabled_q == '0) |-> (irq_vec == 8'h00 && !irq_req)); // R6
  AST_SINGLE_VEC: assert property (@(posedge clk) disable iff (rst)
    ($countones(enabled_q) == 1) |-> (irq_vec >= FIRST_VEC && irq_req)); // R7
  AST_MULTI_VEC: assert property (@(posedge clk) disable iff (rst)
    ($countones(enabled_q) > 1) |-> (irq_vec == SHARED_VEC)); // R8
  AST_MASK_ONLY_IDX0: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(wr_en) && $past(addr) == 3'd0)) |-> $stable(mask_q)); // R3
  AST_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(irq_lines[W-1:NMI_LO]) != '0) |-> nmi_out); // R9
  AST_RAW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    raw_q[W-1:MASKABLE] == '0); // R4
endmodule

// File: tb/tb_masked_vec_irq.sv
`timescale 1ns/100ps
module tb_masked_vec_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req, nmi_out;
  logic [7:0]  irq_vec;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  masked_vec_irq dut (.clk(clk), .rst(rst), .irq_lines(irq_lines), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .nmi_out(nmi_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic drive(input logic [31:0] l);
    @(negedge clk); irq_lines = l;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 vec", {24'b0, irq_vec}, 0);
    chk("R1 req", {31'b0, irq_req}, 0);
    chk("R1 nmi", {31'b0, nmi_out}, 0);
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 word", d, 0); end
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr(0, 32'hA5A5_1234); rd(0, d); chk("R2 mask readback", d, 32'hA5A5_1234);
    wr(0, 32'h0); rd(0, d); chk("R2 mask clear", d, 0);
  endtask

  task automatic t_raw_map();
    logic [31:0] d;
    drive(32'h0000_0001);
    rd(1, d); chk("R4 line0 ignored", d, 0);
    drive(32'h3FFF_FFFE);
    rd(1, d); chk("R4 all maskable", d, 32'h1FFF_FFFF);
    drive(32'h0000_0402);
    rd(1, d); chk("R4 lines 1,10", d, 32'h0000_0201);
    drive(32'h0);
    rd(1, d); chk("R4 level clear", d, 0);
  endtask

  task automatic t_masked_word();
    logic [31:0] d;
    wr(0, 32'h0000_00F0);
    drive(32'h0000_0666);
    rd(2, d); chk("R5 masked word", d, 32'h0000_0333 & 32'h0000_00F0);
    drive(32'h0);
  endtask

  task automatic t_idle();
    wr(0, 32'h0);
    drive(32'h0000_00FE);
    chk("R6 masked off vec", {24'b0, irq_vec}, 0);
    chk("R6 masked off req", {31'b0, irq_req}, 0);
    drive(32'h0);
  endtask

  task automatic t_single();
    wr(0, 32'hFFFF_FFFF);
    for (int n = 1; n < 30; n++) begin
      drive(32'h1 << n);
      chk("R7 single vec", {24'b0, irq_vec}, 32'h31 + n - 1);
      chk("R7 single req", {31'b0, irq_req}, 1);
    end
    drive(32'h0);
    chk("R6 none vec", {24'b0, irq_vec}, 0);
  endtask

  task automatic t_multi();
    wr(0, 32'hFFFF_FFFF);
    drive(32'h0000_0088);
    chk("R8 multi vec", {24'b0, irq_vec}, 32'h30);
    chk("R8 multi req", {31'b0, irq_req}, 1);
    wr(0, 32'h0000_0004);
    chk("R7 narrowed by mask", {24'b0, irq_vec}, 32'h33);
    drive(32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(0, 32'h0000_0005);
    drive(32'h0000_0002);
    for (int a = 1; a < 8; a++) wr(3'(a), 32'hFFFF_FFFF);
    rd(0, d); chk("R3 mask kept", d, 32'h5);
    rd(1, d); chk("R3 raw kept", d, 32'h1);
    rd(3, d); chk("R3 nmi kept", d, 0);
    rd(4, d); chk("R3 guru kept", d, 0);
    chk("R3 vec kept", {24'b0, irq_vec}, 32'h31);
    drive(32'h0);
  endtask

  task automatic t_nmi();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    drive(32'h4000_0000);
    chk("R9 nmi line30", {31'b0, nmi_out}, 1);
    chk("R9 no vec", {24'b0, irq_vec}, 0);
    rd(3, d); chk("R9 nmi word", d, 32'h4000_0000);
    rd(1, d); chk("R9 raw untouched", d, 0);
    drive(32'hC000_0000);
    rd(3, d); chk("R9 both", d, 32'hC000_0000);
    drive(32'h8000_0000);
    chk("R9 nmi line31", {31'b0, nmi_out}, 1);
    drive(32'h0);
    chk("R9 nmi clear", {31'b0, nmi_out}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    drive(32'hFFFF_FFFF);
    for (int a = 4; a < 8; a++) begin rd(3'(a), d); chk("R10 zero word", d, 0); end
    drive(32'h0);
  endtask

  task automatic t_latency();
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk); irq_lines = 32'h0000_0010;
    #1 chk("R11 not before edge", {24'b0, irq_vec}, 0);
    @(posedge clk); #1 chk("R11 after edge", {24'b0, irq_vec}, 32'h34);
    chk("R11 nmi quiet", {31'b0, nmi_out}, 0);
    @(negedge clk); irq_lines = 32'h4000_0000;
    #1 chk("R11 nmi not before edge", {31'b0, nmi_out}, 0);
    @(posedge clk); #1 chk("R11 nmi after edge", {31'b0, nmi_out}, 1);
    chk("R11 vec drops", {24'b0, irq_vec}, 0);
    drive(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_mask_rw(); t_raw_map(); t_masked_word(); t_idle();
    t_single(); t_multi(); t_ignored(); t_nmi(); t_unmapped(); t_latency();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule